// File: doc/BRIEF.md
# Fused Two-Instruction ALU

This block is a 64-bit integer execution unit for merged operations. An earlier decode stage finds two adjacent RV64 integer instructions that form a known idiom. It then issues one internal operation in their place. This unit computes that operation's result in a single pass. It returns exactly the value that the second instruction of the original pair would have written.

The inputs are two 64-bit operands and a 5-bit operation code. The operation families are:

- shifts of a zero-extended word;
- extraction of the second byte;
- shift-then-add, to the left and to the right;
- adding the low bit of a value;
- OR with a byte-cleared mask;
- a 32-bit add followed by narrow extraction;
- a logic operation followed by narrow extraction.

When an operand stands for an immediate, it arrives already sign-extended. The result can be registered (`USE_OUT_REG = 1`, the default), which gives one cycle of latency with a valid flag that travels alongside it. It can also be left combinational.

Top module: `pair_fuse_alu`

## Requirements
- R1: Codes 0, 1 and 2 return the low 32 bits of src_a, zero-extended to 64 bits and shifted left by 1, 2 and 3. This equals a left shift by 32 followed by a logical right shift by 32 minus the amount.
- R2: Code 3 returns bits 15:8 of src_a in result bits 7:0, with every upper bit zero.
- R3: Code 4 returns (src_a shifted left by 4) plus src_b, modulo 2^64.
- R4: Codes 5, 6, 7 and 8 return src_a logically shifted right by 29, 30, 31 and 32, plus src_b, modulo 2^64.
- R5: Code 9 returns src_a bit 0 plus src_b, modulo 2^64. Code 10 adds src_a bit 0 to the low 32 bits of src_b in 32 bits, then sign-extends bit 31 of that sum to 64 bits.
- R6: Code 11 returns src_a with its low 8 bits cleared, ORed with src_b.
- R7: Codes 12 to 15 first form the 32-bit sum of the low words of src_a and src_b. They then return, in order: its low 8 bits zero-extended; its bit 0 alone; its low 16 bits zero-extended; its low 16 bits sign-extended from bit 15.
- R8: Codes 16 to 19 apply AND, OR, XOR and OR-combine-bytes respectively, and return only bit 0 of that logic result. OR-combine-bytes makes each byte 0xFF when the matching src_a byte is nonzero and 0x00 otherwise; it ignores src_b. Bits 1:0 of the code pick the logic operation.
- R9: Codes 20 to 23 apply the same four logic operations, picked by code bits 1:0, and return the low 16 bits of the logic result, zero-extended.
- R10: Codes 24 to 31 return zero, whatever the operands are.
- R11: With the output register in place, reset clears out_vld and result. A value presented with in_vld high appears on result, with out_vld high, after the next rising clock edge. out_vld is low in any cycle that follows a cycle with in_vld low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Operands and code are valid this cycle |
| op_code | input | 5 | Fused operation code |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand or sign-extended immediate |
| out_vld | output | 1 | Result is valid |
| result | output | 64 | Fused result |

## Verification
The bench models every code as the original two instructions executed one after the other, and compares the result against that model. The operands include all ones, 0x8000_0000, 0xFFFF_FFFF, and values with only bit 15 or bit 31 set. These are where a sign/zero mix-up would show:

- a word-add path that sign-extends the wrong bit leaks ones into the upper half;
- an odd-add word variant computed in 64 bits misses the wrap at bit 31;
- a right-shift-add using an arithmetic shift fills the top with copies of bit 63;
- a masked OR that clears 12 bits instead of 8 loses bits 11:8 of src_a.

Unused codes are driven with all-ones operands, so a design that decodes them into any operation produces a nonzero result.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int unsigned XLEN     = 64;
  localparam int unsigned WLEN     = XLEN / 2;
  localparam int unsigned HLEN     = 16;
  localparam int unsigned BLEN     = 8;
  localparam int unsigned NBYTES   = XLEN / BLEN;
  localparam int unsigned OPC_W    = 5;
  localparam int unsigned ZW_CNT   = 3;   // word-shift amounts 1..3
  localparam int unsigned SRA_BASE = 29;  // first right-shift-add amount
  localparam int unsigned SRA_CNT  = 4;   // 29..32

  typedef enum logic [OPC_W-1:0] {
    FOP_ZWSL1   = 5'd0,  FOP_ZWSL2  = 5'd1,  FOP_ZWSL3  = 5'd2,
    FOP_BYTE1   = 5'd3,  FOP_SL4ADD = 5'd4,
    FOP_SR29ADD = 5'd5,  FOP_SR30ADD = 5'd6, FOP_SR31ADD = 5'd7, FOP_SR32ADD = 5'd8,
    FOP_ODDADD  = 5'd9,  FOP_ODDADDW = 5'd10, FOP_MASKOR = 5'd11,
    FOP_WA_B8   = 5'd12, FOP_WA_B1  = 5'd13, FOP_WA_ZH  = 5'd14, FOP_WA_SH  = 5'd15,
    FOP_AND_LSB = 5'd16, FOP_OR_LSB = 5'd17, FOP_XOR_LSB = 5'd18, FOP_ORC_LSB = 5'd19,
    FOP_AND_ZH  = 5'd20, FOP_OR_ZH  = 5'd21, FOP_XOR_ZH  = 5'd22, FOP_ORC_ZH  = 5'd23
  } fuse_op_e;

  function automatic logic [XLEN-1:0] f_zw_shl(logic [XLEN-1:0] a, int unsigned n);
    logic [XLEN-1:0] z;
    z = {{(XLEN-WLEN){1'b0}}, a[WLEN-1:0]};
    return z << n;
  endfunction

  function automatic logic [XLEN-1:0] f_orcb(logic [XLEN-1:0] a);
    logic [XLEN-1:0] r;
    for (int i = 0; i < NBYTES; i++)
      r[i*BLEN +: BLEN] = (|a[i*BLEN +: BLEN]) ? {BLEN{1'b1}} : {BLEN{1'b0}};
    return r;
  endfunction

  function automatic logic [XLEN-1:0] f_logic(logic [1:0] kind, logic [XLEN-1:0] a,
                                              logic [XLEN-1:0] b);
    case (kind)
      2'd0:    return a & b;
      2'd1:    return a | b;
      2'd2:    return a ^ b;
      default: return f_orcb(a);
    endcase
  endfunction

  function automatic logic [WLEN-1:0] f_wsum(logic [XLEN-1:0] a, logic [XLEN-1:0] b);
    return a[WLEN-1:0] + b[WLEN-1:0];
  endfunction

  function automatic logic [XLEN-1:0] f_zext16(logic [HLEN-1:0] h);
    return {{(XLEN-HLEN){1'b0}}, h};
  endfunction

  function automatic logic [XLEN-1:0] f_sext16(logic [HLEN-1:0] h);
    return {{(XLEN-HLEN){h[HLEN-1]}}, h};
  endfunction
endpackage

// File: rtl/fuse_shift_unit.sv
module fuse_shift_unit
  import fuse_pkg::*;
(
  input  fuse_op_e        op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            hit_o,
  output logic [XLEN-1:0] res_o
);
  logic [XLEN-1:0] zw_res  [ZW_CNT];
  logic [XLEN-1:0] sra_res [SRA_CNT];
  logic [WLEN-1:0] oddw_sum;

  for (genvar g = 0; g < ZW_CNT; g++) begin : g_zw
    assign zw_res[g] = f_zw_shl(a_i, g + 1);
  end

  for (genvar g = 0; g < SRA_CNT; g++) begin : g_sra
    assign sra_res[g] = (a_i >> (SRA_BASE + g)) + b_i;
  end

  assign oddw_sum = {{(WLEN-1){1'b0}}, a_i[0]} + b_i[WLEN-1:0];

  always_comb begin
    hit_o = 1'b1;
    res_o = '0;
    case (op_i)
      FOP_ZWSL1:   res_o = zw_res[0];
      FOP_ZWSL2:   res_o = zw_res[1];
      FOP_ZWSL3:   res_o = zw_res[2];
      FOP_BYTE1:   res_o = {{(XLEN-BLEN){1'b0}}, a_i[2*BLEN-1:BLEN]};
      FOP_SL4ADD:  res_o = (a_i << 4) + b_i;
      FOP_SR29ADD: res_o = sra_res[0];
      FOP_SR30ADD: res_o = sra_res[1];
      FOP_SR31ADD: res_o = sra_res[2];
      FOP_SR32ADD: res_o = sra_res[3];
      FOP_ODDADD:  res_o = {{(XLEN-1){1'b0}}, a_i[0]} + b_i;
      FOP_ODDADDW: res_o = {{(XLEN-WLEN){oddw_sum[WLEN-1]}}, oddw_sum};
      FOP_MASKOR:  res_o = {a_i[XLEN-1:BLEN], {BLEN{1'b0}}} | b_i;
      default:     hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fuse_narrow_unit.sv
module fuse_narrow_unit
  import fuse_pkg::*;
(
  input  fuse_op_e        op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            hit_o,
  output logic [XLEN-1:0] res_o
);
  logic [WLEN-1:0] wsum;
  logic [XLEN-1:0] lres;
  logic            is_wadd, is_logic;

  assign wsum     = f_wsum(a_i, b_i);
  assign lres     = f_logic(op_i[1:0], a_i, b_i);
  assign is_wadd  = (op_i >= FOP_WA_B8) && (op_i <= FOP_WA_SH);
  assign is_logic = (op_i >= FOP_AND_LSB) && (op_i <= FOP_ORC_ZH);
  assign hit_o    = is_wadd | is_logic;

  always_comb begin
    res_o = '0;
    if (is_wadd) begin
      case (op_i[1:0])
        2'd0:    res_o = {{(XLEN-BLEN){1'b0}}, wsum[BLEN-1:0]};
        2'd1:    res_o = {{(XLEN-1){1'b0}}, wsum[0]};
        2'd2:    res_o = f_zext16(wsum[HLEN-1:0]);
        default: res_o = f_sext16(wsum[HLEN-1:0]);
      endcase
    end else if (is_logic) begin
      if (op_i[2]) res_o = f_zext16(lres[HLEN-1:0]);
      else         res_o = {{(XLEN-1){1'b0}}, lres[0]};
    end
  end
endmodule

// File: rtl/pair_fuse_alu.sv
module pair_fuse_alu
  import fuse_pkg::*;
#(
  parameter bit USE_OUT_REG = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_vld,
  input  logic [OPC_W-1:0] op_code,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic            out_vld,
  output logic [XLEN-1:0] result
);
  fuse_op_e        op;
  logic            sh_hit, nw_hit;
  logic [XLEN-1:0] sh_res, nw_res, comb_res;

  assign op = fuse_op_e'(op_code);

  fuse_shift_unit u_shift (.op_i(op), .a_i(src_a), .b_i(src_b), .hit_o(sh_hit), .res_o(sh_res));
  fuse_narrow_unit u_narrow (.op_i(op), .a_i(src_a), .b_i(src_b), .hit_o(nw_hit), .res_o(nw_res));

  always_comb begin
    if (sh_hit)      comb_res = sh_res;
    else if (nw_hit) comb_res = nw_res;
    else             comb_res = '0;
  end

  if (USE_OUT_REG) begin : g_reg
    logic            vld_q;
    logic [XLEN-1:0] res_q;

    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        res_q <= '0;
      end else begin
        vld_q <= in_vld;
        if (in_vld) res_q <= comb_res;
      end
    end
    assign out_vld = vld_q;
    assign result  = res_q;

    assert_vld_follow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_vld |=> out_vld);
    assert_vld_drop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_vld |=> !out_vld);
    assert_unused_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_vld && op_code >= 5'd24) |=> (result == '0));
    assert_units_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({sh_hit, nw_hit}));
    assert_zw_bounds_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_vld && op_code <= 5'd2) |=> (result[XLEN-1:WLEN+3] == '0 && result[0] == 1'b0));
    assert_byte_pick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_vld && op == FOP_BYTE1) |=>
        (result[XLEN-1:BLEN] == '0 && result[BLEN-1:0] == $past(src_a[2*BLEN-1:BLEN])));
    assert_oddw_sext_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_vld && op == FOP_ODDADDW) |=> (result[XLEN-1:WLEN] == {WLEN{result[WLEN-1]}}));
    assert_maskor_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_vld && op == FOP_MASKOR) |=> (result[BLEN-1:0] == $past(src_b[BLEN-1:0])));
    assert_wadd_sext_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_vld && op == FOP_WA_SH) |=> (result[XLEN-1:HLEN] == {(XLEN-HLEN){result[HLEN-1]}}));
    assert_logic_lsb_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_vld && op_code >= 5'd16 && op_code <= 5'd19) |=> (result[XLEN-1:1] == '0));
    assert_logic_zh_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_vld && op_code >= 5'd20 && op_code <= 5'd23) |=> (result[XLEN-1:HLEN] == '0));
  end else begin : g_comb
    assign out_vld = in_vld;
    assign result  = comb_res;
  end
endmodule

// File: tb/sim_pair_fuse_alu.sv
module sim_pair_fuse_alu;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_vld = 1'b0;
  logic [4:0]  op_code = '0;
  logic [63:0] src_a = '0, src_b = '0;
  logic        out_vld;
  logic [63:0] result;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [63:0] exp_q [$];
  string       tag_q [$];
  int          op_q  [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pair_fuse_alu u0 (.clk_i(clk), .rst_ni(rst_ni), .in_vld(in_vld), .op_code(op_code),
                    .src_a(src_a), .src_b(src_b), .out_vld(out_vld), .result(result));

  function automatic logic [63:0] sx12(logic [11:0] imm);
    return {{52{imm[11]}}, imm};
  endfunction

  function automatic logic [63:0] orc(logic [63:0] a);
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++)
      if (((a >> (8*i)) & 64'hFF) != 0) r = r | (64'hFF << (8*i));
    return r;
  endfunction

  // two original instructions executed one after the other
  function automatic logic [63:0] model(int op, logic [63:0] a, logic [63:0] b);
    logic [63:0] t, r;
    logic [31:0] w;
    r = '0;
    if (op <= 2) begin t = a << 32; r = t >> (31 - op); end
    else if (op == 3) begin t = a >> 8; r = t & sx12(12'd255); end
    else if (op == 4) begin t = a << 4; r = t + b; end
    else if (op <= 8) begin t = a >> (op + 24); r = t + b; end
    else if (op == 9) begin t = a & sx12(12'd1); r = t + b; end
    else if (op == 10) begin
      t = a & sx12(12'd1); w = t[31:0] + b[31:0]; r = {{32{w[31]}}, w};
    end
    else if (op == 11) begin t = a & sx12(12'hF00); r = t | b; end
    else if (op <= 15) begin
      w = a[31:0] + b[31:0]; t = {{32{w[31]}}, w};
      if (op == 12)      r = t & sx12(12'd255);
      else if (op == 13) r = t & sx12(12'd1);
      else if (op == 14) r = {48'd0, t[15:0]};
      else               r = {{48{t[15]}}, t[15:0]};
    end
    else if (op <= 23) begin
      case (op % 4)
        0: t = a & b;
        1: t = a | b;
        2: t = a ^ b;
        default: t = orc(a);
      endcase
      r = (op < 20) ? (t & sx12(12'd1)) : {48'd0, t[15:0]};
    end
    return r;
  endfunction

  function automatic string req_of(int op);
    if (op <= 2)  return "R1";
    if (op == 3)  return "R2";
    if (op == 4)  return "R3";
    if (op <= 8)  return "R4";
    if (op <= 10) return "R5";
    if (op == 11) return "R6";
    if (op <= 15) return "R7";
    if (op <= 19) return "R8";
    if (op <= 23) return "R9";
    return "R10";
  endfunction

  task automatic drive(int op, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    in_vld  = 1'b1;
    op_code = op[4:0];
    src_a   = a;
    src_b   = b;
    exp_q.push_back(model(op, a, b));
    tag_q.push_back(req_of(op));
    op_q.push_back(op);
  endtask

  // monitor: result is registered, so it is compared one negedge after driving (R11)
  initial begin
    forever begin
      @(negedge clk);
      if (out_vld) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R11 unexpected out_vld got=1 exp=0");
        end else begin
          logic [63:0] e;
          string tg;
          int o;
          e = exp_q.pop_front(); tg = tag_q.pop_front(); o = op_q.pop_front();
          if (result !== e) begin
            n_fail++;
            $display("FAIL %s op=%0d got=%h exp=%h", tg, o, result, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  logic [63:0] corners [8];

  initial begin
    corners[0] = 64'h0;
    corners[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    corners[2] = 64'h0000_0000_8000_0000;
    corners[3] = 64'h0000_0000_FFFF_FFFF;
    corners[4] = 64'h0000_0000_0000_8000;
    corners[5] = 64'h8000_0000_0000_0000;
    corners[6] = 64'h0000_0000_7FFF_FFFF;
    corners[7] = 64'h1234_5678_9ABC_DEF1;

    repeat (3) @(negedge clk);
    // R11: reset state
    n_chk++;
    if (out_vld !== 1'b0 || result !== 64'h0) begin
      n_fail++;
      $display("FAIL R11 reset got vld=%b res=%h exp vld=0 res=0", out_vld, result);
    end
    @(negedge clk);
    rst_ni = 1'b1;

    for (int op = 0; op < 32; op++) begin
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          drive(op, corners[i], corners[j]);
      for (int k = 0; k < 24; k++)
        drive(op, {$urandom, $urandom}, {$urandom, $urandom});
      // idle gap: out_vld must drop (R11)
      @(negedge clk);
      in_vld = 1'b0;
      @(negedge clk);
      n_chk++;
      if (out_vld !== 1'b0) begin
        n_fail++;
        $display("FAIL R11 idle got vld=%b exp=0", out_vld);
      end
    end

    repeat (3) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R11 pending results got=%0d exp=0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule